// File: doc/BRIEF.md
# Half-Bridge Cross-Conduction Interlock with Fault Capture

This block sits between a controller's high-side and low-side PWM signals and the two gate drivers of a half bridge. Each driver reports back an off-state flag, which is high when its gate is held low and its switch is off. The block passes a side's PWM request on to its driver only while the opposite driver reports off. It therefore uses live feedback from the drivers to keep the two switches from conducting together, with no fixed dead-time counter.

The same feedback is used for fault capture. When a side's PWM is high but its own driver still reports off, protection inside the driver has ended the pulse early. Each side raises a fault flag once that condition has lasted a parameter-set number of clock cycles. The delay masks the normal turn-on delay of the driver. The flag then holds until a clear input is pulsed. All four feedback and PWM inputs pass through a synchronizer before they are used. If both PWM inputs request on at once, neither driver input is asserted until one of the requests drops.

Top module: `hb_interlock`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all four outputs are low.
- R2: With the low-side PWM low and the low-side off flag high, the high-side driver output follows the high-side PWM with a latency of three clock edges: two synchronizer stages and one output register.
- R3: With the high-side PWM low and the high-side off flag high, the low-side driver output follows the low-side PWM with the same three-edge latency.
- R4: While the opposite side's off flag is low (its switch is on), a side's driver output stays low whatever its PWM does.
- R5: While both PWM inputs are high, both driver outputs are low. Once one request drops, the other side drives again after three edges.
- R6: A side's fault flag rises once that side's PWM and that side's off flag have both been high for FAULT_MASK_CYC consecutive cycles.
- R7: A PWM-high-while-off condition that lasts FAULT_MASK_CYC-1 cycles or fewer leaves the fault flag low.
- R8: A raised fault flag stays high after the condition ends, until the clear input is sampled high. It is low from the next clock edge on.
- R9: The two fault flags are independent: a fault on one side leaves the other side's flag low.
- R10: A normal turn-on leaves the fault flag low. In a normal turn-on the side's off flag drops within the mask window and stays low while its PWM is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_hs_i | input | 1 | High-side PWM request from the controller |
| pwm_ls_i | input | 1 | Low-side PWM request from the controller |
| off_hs_i | input | 1 | High-side driver off-state flag (1 = switch off) |
| off_ls_i | input | 1 | Low-side driver off-state flag (1 = switch off) |
| flt_clr_i | input | 1 | Synchronous clear of both fault flags |
| drv_hs_o | output | 1 | Gated high-side driver input |
| drv_ls_o | output | 1 | Gated low-side driver input |
| flt_hs_o | output | 1 | Latched high-side fault flag |
| flt_ls_o | output | 1 | Latched low-side fault flag |

## Verification
The bench probes the fault mask at its edge. A condition one cycle shorter than the window must leave the flag low, and one exactly as long as the window must raise it. A design with an off-by-one counter fails one of these two cases. Simultaneous requests from both sides are held for several cycles, and then one request is dropped. A design that lets either side through during the overlap, or that never releases the remaining side, is caught. The bench also blocks a side through the opposite off flag. It checks that a latched fault survives the end of its condition and falls right after a clear, and that one side's fault leaves the other flag low. Each drive check is sampled one edge early as well, which catches a wrong pipeline depth.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
   localparam int SIDES = 2;
   localparam int HS    = 0;
   localparam int LS    = 1;
   typedef logic [SIDES-1:0] side_vec_t;

   function automatic int opposite(input int side);
      return (side == HS) ? LS : HS;
   endfunction
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hbi_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hbi_sync: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= '0;
         else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain_q[STAGES-1];
   end
endmodule

// File: rtl/hbi_gate.sv
module hbi_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwm_own_i,
   input  logic pwm_opp_i,
   input  logic off_opp_i,
   output logic drv_o
);
   logic allow;
   assign allow = off_opp_i & ~pwm_opp_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) drv_o <= 1'b0;
      else         drv_o <= pwm_own_i & allow;
   end

   // R4: opposite switch on blocks this side on the next edge
   p_blocked_by_opp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !off_opp_i |=> !drv_o);
   // R5: an opposite request blocks this side on the next edge
   p_blocked_by_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwm_opp_i |=> !drv_o);
endmodule

// File: rtl/hbi_fault.sv
module hbi_fault #(
   parameter int MASK_CYC = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwm_i,
   input  logic off_i,
   input  logic clr_i,
   output logic flt_o
);
   localparam int CNT_W = (MASK_CYC < 2) ? 1 : $clog2(MASK_CYC);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(MASK_CYC - 1);

   if (MASK_CYC < 1) begin : g_bad_mask
      $error("hbi_fault: MASK_CYC must be at least 1");
   end

   logic             cond;
   logic [CNT_W-1:0] cnt_q;
   logic             hit;

   assign cond = pwm_i & off_i;
   assign hit  = cond && (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (clr_i || !cond)    cnt_q <= '0;
      else if (cnt_q != LAST)     cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flt_o <= 1'b0;
      else if (clr_i)  flt_o <= 1'b0;
      else if (hit)    flt_o <= 1'b1;
   end

   // R8: flag holds without a clear
   p_flag_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flt_o && !clr_i) |=> flt_o);
   // R8: clear drops the flag on the next edge
   p_flag_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !flt_o);
   // R6: the flag rises only while the fault condition is present
   p_rise_needs_cond_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flt_o) |-> $past(pwm_i && off_i));
endmodule

// File: rtl/hb_interlock.sv
module hb_interlock #(
   parameter int SYNC_STAGES    = 2,
   parameter int FAULT_MASK_CYC = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwm_hs_i,
   input  logic pwm_ls_i,
   input  logic off_hs_i,
   input  logic off_ls_i,
   input  logic flt_clr_i,
   output logic drv_hs_o,
   output logic drv_ls_o,
   output logic flt_hs_o,
   output logic flt_ls_o
);
   import hbi_pkg::*;

   localparam int SYNC_W = 2 * SIDES;

   side_vec_t         pwm_s, off_s, drv, flt;
   logic [SYNC_W-1:0] raw, synced;

   assign raw   = {off_ls_i, off_hs_i, pwm_ls_i, pwm_hs_i};
   assign pwm_s = synced[SIDES-1:0];
   assign off_s = synced[SYNC_W-1:SIDES];

   hbi_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw),
      .q_o   (synced)
   );

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      localparam int OPP = opposite(s);

      hbi_gate u_gate (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .pwm_own_i(pwm_s[s]),
         .pwm_opp_i(pwm_s[OPP]),
         .off_opp_i(off_s[OPP]),
         .drv_o    (drv[s])
      );

      hbi_fault #(.MASK_CYC(FAULT_MASK_CYC)) u_fault (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .pwm_i (pwm_s[s]),
         .off_i (off_s[s]),
         .clr_i (flt_clr_i),
         .flt_o (flt[s])
      );
   end

   assign drv_hs_o = drv[HS];
   assign drv_ls_o = drv[LS];
   assign flt_hs_o = flt[HS];
   assign flt_ls_o = flt[LS];

   // R5: the two driver inputs are never high together
   p_no_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(drv_hs_o && drv_ls_o));
   // R2: high-side drive implies the low side reported off one edge earlier
   p_hs_needs_ls_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(drv_hs_o) |-> $past(off_s[LS]));
   // R3: low-side drive implies the high side reported off one edge earlier
   p_ls_needs_hs_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(drv_ls_o) |-> $past(off_s[HS]));
endmodule

// File: tb/tb_hb_interlock.sv
module tb_hb_interlock;
   localparam int MASK = 6;
   localparam int WD_LIMIT = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_hs = 1'b0, pwm_ls = 1'b0, off_hs = 1'b1, off_ls = 1'b1, clr = 1'b0;
   logic drv_hs, drv_ls, flt_hs, flt_ls;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   hb_interlock #(.SYNC_STAGES(2), .FAULT_MASK_CYC(MASK)) dut (
      .clk_i(clk), .rst_ni(rst_n),
      .pwm_hs_i(pwm_hs), .pwm_ls_i(pwm_ls),
      .off_hs_i(off_hs), .off_ls_i(off_ls),
      .flt_clr_i(clr),
      .drv_hs_o(drv_hs), .drv_ls_o(drv_ls),
      .flt_hs_o(flt_hs), .flt_ls_o(flt_ls)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic idle();
      pwm_hs = 0; pwm_ls = 0; off_hs = 1; off_ls = 1; clr = 0;
      wait_n(4);
   endtask

   task automatic do_clear();
      clr = 1; wait_n(1); clr = 0;
   endtask

   task automatic t_reset();
      wait_n(3);
      chk("R1", "drv_hs in reset", drv_hs, 0);
      chk("R1", "drv_ls in reset", drv_ls, 0);
      chk("R1", "flt_hs in reset", flt_hs, 0);
      chk("R1", "flt_ls in reset", flt_ls, 0);
      rst_n = 1; wait_n(1);
      chk("R1", "drv_hs after reset", drv_hs, 0);
      chk("R1", "flt_ls after reset", flt_ls, 0);
   endtask

   task automatic t_hs_pass();
      pwm_hs = 1; off_hs = 0;
      wait_n(2);
      chk("R2", "drv_hs after two edges", drv_hs, 0);
      wait_n(1);
      chk("R2", "drv_hs after three edges", drv_hs, 1);
      chk("R2", "drv_ls stays low", drv_ls, 0);
      pwm_hs = 0; off_hs = 1;
      wait_n(3);
      chk("R2", "drv_hs follows low", drv_hs, 0);
      chk("R10", "no hs fault on normal pulse", flt_hs, 0);
      idle();
   endtask

   task automatic t_ls_pass();
      pwm_ls = 1; off_ls = 0;
      wait_n(2);
      chk("R3", "drv_ls after two edges", drv_ls, 0);
      wait_n(1);
      chk("R3", "drv_ls after three edges", drv_ls, 1);
      chk("R3", "drv_hs stays low", drv_hs, 0);
      pwm_ls = 0; off_ls = 1;
      wait_n(3);
      chk("R3", "drv_ls follows low", drv_ls, 0);
      idle();
   endtask

   task automatic t_block();
      off_ls = 0; pwm_hs = 1;
      wait_n(4);
      chk("R4", "hs blocked by ls on", drv_hs, 0);
      off_ls = 1; off_hs = 1; pwm_hs = 0;
      off_hs = 0; pwm_ls = 1;
      wait_n(4);
      chk("R4", "ls blocked by hs on", drv_ls, 0);
      idle();
      do_clear(); wait_n(1);
   endtask

   task automatic t_both();
      pwm_hs = 1; pwm_ls = 1;
      for (int i = 0; i < 4; i++) begin
         wait_n(1);
         chk("R5", "drv_hs low with both requests", drv_hs, 0);
         chk("R5", "drv_ls low with both requests", drv_ls, 0);
      end
      pwm_ls = 0; off_hs = 0;
      wait_n(3);
      chk("R5", "hs drives after ls request drops", drv_hs, 1);
      chk("R5", "ls stays low", drv_ls, 0);
      chk("R7", "short overlap gives no hs fault", flt_hs, 0);
      chk("R7", "short overlap gives no ls fault", flt_ls, 0);
      idle();
   endtask

   task automatic t_fault_short();
      pwm_hs = 1; off_hs = 1;
      wait_n(MASK - 1);
      pwm_hs = 0;
      wait_n(MASK + 4);
      chk("R7", "hs condition MASK-1 cycles", flt_hs, 0);
      idle();
   endtask

   task automatic t_fault_hs();
      pwm_hs = 1; off_hs = 1;
      wait_n(MASK);
      pwm_hs = 0;
      wait_n(4);
      chk("R6", "hs condition MASK cycles", flt_hs, 1);
      chk("R9", "ls flag untouched", flt_ls, 0);
      wait_n(10);
      chk("R8", "hs flag held after condition ends", flt_hs, 1);
      clr = 1; wait_n(1); clr = 0;
      chk("R8", "hs flag low after clear", flt_hs, 0);
      wait_n(3);
      chk("R8", "hs flag stays clear", flt_hs, 0);
      idle();
   endtask

   task automatic t_fault_ls();
      pwm_ls = 1; off_ls = 1;
      wait_n(MASK + 3);
      pwm_ls = 0;
      wait_n(4);
      chk("R6", "ls condition long", flt_ls, 1);
      chk("R9", "hs flag untouched", flt_hs, 0);
      do_clear();
      chk("R8", "ls flag low after clear", flt_ls, 0);
      idle();
   endtask

   task automatic t_normal_on();
      pwm_hs = 1;
      wait_n(2);
      off_hs = 0;
      wait_n(20);
      chk("R10", "normal turn-on no fault", flt_hs, 0);
      chk("R2", "hs driving during long pulse", drv_hs, 1);
      idle();
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      idle();
      t_hs_pass();
      t_ls_pass();
      t_block();
      t_both();
      t_fault_short();
      t_fault_hs();
      t_fault_ls();
      t_normal_on();
      finish_up();
   end

   initial begin
      for (int c = 0; c < WD_LIMIT; c++) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end
endmodule